// File: doc/BRIEF.md
# Mailbox Register File with Message Interrupts

This block holds eight 32-bit message words shared between a host-side agent and a local-side agent. The host reaches every word, together with an interrupt control/status word and a queue control word, through a word-addressed register port with separate write and read strobes. The local side has its own read port that selects a mailbox by index. A host write to one of the four lowest mailboxes can post a pending flag, and an enabled pending flag raises the local interrupt. The local agent acknowledges a message by reading that mailbox, or by writing ones to the flag bits in the control/status word.

Bit 0 of the queue control word selects the address map. In the direct map, mailboxes 0 and 1 answer at their normal words. In the queue map those two words belong to queue ports that are not part of this block: writes there are dropped and reads return zero. Mailboxes 0 and 1 answer at two alternate words in both maps.

Two small state machines set the behaviour. The map-mode machine has the states MAP_DIRECT and MAP_QUEUE. A host write of the queue control word with bit 0 = 1 takes it from MAP_DIRECT to MAP_QUEUE, and the same write with bit 0 = 0 takes it back. Each of the four flag machines has the states FLAG_IDLE and FLAG_PENDING. It goes from FLAG_IDLE to FLAG_PENDING on an enabled host write to its mailbox. It goes from FLAG_PENDING to FLAG_IDLE on a local read of that mailbox or on a write-one-to-clear, unless an enabled host write to the same mailbox comes in the same cycle.

Top module: `mbx_regfile`

## Requirements
- R1: After reset every mailbox reads 0, the control/status word reads 0, the queue control word reads 0x00000050 (direct map) and loc_irq is low.
- R2: A host write to word 0x10+n stores host_wdata in mailbox n (for mailboxes 2 to 7 in any map, and for 0 and 1 in the direct map). A host read registers the addressed value into host_rdata on the same clock edge. A local read registers mailbox loc_sel into loc_rdata on the same clock edge.
- R3: Words 0x1E and 0x1F reach mailboxes 0 and 1 for writes and reads in both maps.
- R4: In the queue map (queue control bit 0 = 1), host writes to words 0x10 and 0x11 change no mailbox and no flag, and host reads of those words return 0.
- R5: A host write to mailbox n, for n from 0 to 3, sets status bit 28+n of the control/status word (word 0x18) only when the enable bit (bit 3) is 1.
- R6: Host writes to mailboxes 4 to 7 store data and change no status bit.
- R7: loc_irq is high exactly when the enable bit is 1 and at least one of status bits 31:28 is 1. Clearing the enable keeps the status bits.
- R8: A local read of mailbox n (n from 0 to 3) clears status bit 28+n. When an enabled host write to the same mailbox falls in the same cycle, the bit stays set.
- R9: A host write to word 0x18 stores bit 3 as the enable and clears each status bit whose bit in bits 31:28 is 1, leaving the others. Bits 31:28 read back as status, bit 3 as the enable, and every other bit reads 0.
- R10: Host reads of any word other than 0x10 to 0x19, 0x1E and 0x1F return 0, and host writes there change nothing.
- R11: The queue control word (word 0x19) stores all 32 bits written and reads them back. Its bit 0 selects the map from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| loc_rd | input | 1 | Local read strobe, acknowledges the flag |
| loc_sel | input | 3 | Local mailbox index |
| loc_rdata | output | 32 | Registered local read data |
| loc_irq | output | 1 | Local message interrupt |

## Verification
The assertions assume that the strobes and address are known on every cycle after reset, and that each cycle carries at most one host address. A host write and a host read in the same cycle use the same word, and the read returns the value from before the write. The bench drives every input on the falling edge, one operation bundle per cycle. Its random addresses fall mostly in the mapped window, with a few unmapped words. Enable changes, write-one-to-clear patterns and map switches are mixed in at random, and local reads also hit mailboxes 4 to 7, which have no flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        MAP_DIRECT  = 1'b0,
        MAP_QUEUE   = 1'b1
    } map_mode_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;
endpackage

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pending_o
);
    flag_state_e st_q, st_d;

    // next state: a new message wins over an acknowledge in the same cycle
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE:    if (set_i) st_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_i && !set_i) st_d = FLAG_IDLE;
            default:      st_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FLAG_IDLE;
        else        st_q <= st_d;
    end

    always_comb pending_o = (st_q == FLAG_PENDING);
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int NUM_MBOX = 8,
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_MBOX-1:0]              wr_en,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_MBOX-1:0][DATA_W-1:0]  data_o
);
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)        word_q <= '0;
            else if (wr_en[i]) word_q <= wdata;
        end
        assign data_o[i] = word_q;
    end
endmodule

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode #(
    parameter int NUM_MBOX  = 8,
    parameter int NUM_ALT   = 2,
    parameter int AW        = 6,
    parameter int MBOX_BASE = 'h10,
    parameter int ALT_BASE  = 'h1E
) (
    input  logic [AW-1:0]       addr,
    input  logic                queue_map,
    output logic [NUM_MBOX-1:0] mb_hit,
    output logic                qport_hit
);
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_hit
        if (i < NUM_ALT) begin : g_movable
            assign mb_hit[i] = ((addr == AW'(MBOX_BASE + i)) && !queue_map)
                             || (addr == AW'(ALT_BASE + i));
        end else begin : g_fixed
            assign mb_hit[i] = (addr == AW'(MBOX_BASE + i));
        end
    end

    always_comb begin
        qport_hit = 1'b0;
        for (int i = 0; i < NUM_ALT; i++) begin
            if (queue_map && addr == AW'(MBOX_BASE + i)) qport_hit = 1'b1;
        end
    end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter int          NUM_MBOX    = 8,
    parameter int          NUM_IRQ     = 4,
    parameter int          NUM_ALT     = 2,
    parameter int          DATA_W      = 32,
    parameter int          AW          = 6,
    parameter int          MBOX_BASE   = 'h10,
    parameter int          ALT_BASE    = 'h1E,
    parameter int          CSR_ADDR    = 'h18,
    parameter int          QCTL_ADDR   = 'h19,
    parameter int          STATUS_LSB  = 28,
    parameter int          IRQ_EN_BIT  = 3,
    parameter logic [31:0] QCTL_RESET  = 32'h0000_0050,
    localparam int         SEL_W       = $clog2(NUM_MBOX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              loc_rd,
    input  logic [SEL_W-1:0]  loc_sel,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              loc_irq
);
    // ---------------- map-mode state machine ----------------
    map_mode_e map_q, map_d;
    logic      queue_map;
    logic      csr_hit, qctl_hit, csr_wr, qctl_wr;

    assign csr_hit  = (host_addr == AW'(CSR_ADDR));
    assign qctl_hit = (host_addr == AW'(QCTL_ADDR));
    assign csr_wr   = host_wr && csr_hit;
    assign qctl_wr  = host_wr && qctl_hit;

    always_comb begin
        map_d = map_q;
        unique case (map_q)
            MAP_DIRECT: if (qctl_wr &&  host_wdata[0]) map_d = MAP_QUEUE;
            MAP_QUEUE:  if (qctl_wr && !host_wdata[0]) map_d = MAP_DIRECT;
            default:    map_d = MAP_DIRECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= QCTL_RESET[0] ? MAP_QUEUE : MAP_DIRECT;
        else        map_q <= map_d;
    end

    always_comb queue_map = (map_q == MAP_QUEUE);

    // remaining queue-control bits are plain storage
    logic [DATA_W-1:1] qctl_rest_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       qctl_rest_q <= QCTL_RESET[DATA_W-1:1];
        else if (qctl_wr) qctl_rest_q <= host_wdata[DATA_W-1:1];
    end

    // ---------------- decode and storage ----------------
    logic [NUM_MBOX-1:0]             mb_hit;
    logic                            qport_hit;
    logic [NUM_MBOX-1:0][DATA_W-1:0] mbox_q;

    mbx_addr_decode #(
        .NUM_MBOX (NUM_MBOX),
        .NUM_ALT  (NUM_ALT),
        .AW       (AW),
        .MBOX_BASE(MBOX_BASE),
        .ALT_BASE (ALT_BASE)
    ) u_decode (
        .addr     (host_addr),
        .queue_map(queue_map),
        .mb_hit   (mb_hit),
        .qport_hit(qport_hit)
    );

    mbx_store #(
        .NUM_MBOX(NUM_MBOX),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (host_wr ? mb_hit : '0),
        .wdata (host_wdata),
        .data_o(mbox_q)
    );

    // ---------------- interrupt enable and flags ----------------
    logic               irq_en_q;
    logic [NUM_IRQ-1:0] flag_set, flag_clr, pending;

    always_ff @(posedge clk) begin
        if (!rst_n)      irq_en_q <= 1'b0;
        else if (csr_wr) irq_en_q <= host_wdata[IRQ_EN_BIT];
    end

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_flag
        assign flag_set[n] = host_wr && mb_hit[n] && irq_en_q;
        assign flag_clr[n] = (loc_rd && loc_sel == SEL_W'(n))
                           || (csr_wr && host_wdata[STATUS_LSB + n]);
        mbx_flag_fsm u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (flag_set[n]),
            .clr_i    (flag_clr[n]),
            .pending_o(pending[n])
        );
    end

    // ---------------- read paths ----------------
    logic [DATA_W-1:0] csr_val, mb_val, host_val;

    always_comb begin
        csr_val                           = '0;
        csr_val[STATUS_LSB +: NUM_IRQ]    = pending;
        csr_val[IRQ_EN_BIT]               = irq_en_q;
    end

    always_comb begin
        mb_val = '0;
        for (int i = 0; i < NUM_MBOX; i++) begin
            if (mb_hit[i]) mb_val = mb_val | mbox_q[i];
        end
    end

    always_comb begin
        if (|mb_hit)        host_val = mb_val;
        else if (qport_hit) host_val = '0;
        else if (csr_hit)   host_val = csr_val;
        else if (qctl_hit)  host_val = {qctl_rest_q, queue_map};
        else                host_val = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
            loc_rdata  <= '0;
        end else begin
            if (host_rd) host_rdata <= host_val;
            if (loc_rd)  loc_rdata  <= mbox_q[loc_sel];
        end
    end

    // ---------------- outputs ----------------
    always_comb loc_irq = irq_en_q && (|pending);
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk #(
    parameter int NUM_MBOX   = 8,
    parameter int NUM_IRQ    = 4,
    parameter int NUM_ALT    = 2,
    parameter int DATA_W     = 32,
    parameter int AW         = 6,
    parameter int MBOX_BASE  = 'h10,
    parameter int ALT_BASE   = 'h1E,
    parameter int CSR_ADDR   = 'h18,
    parameter int QCTL_ADDR  = 'h19,
    localparam int SEL_W     = $clog2(NUM_MBOX)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            host_wr,
    input logic                            host_rd,
    input logic [AW-1:0]                   host_addr,
    input logic [DATA_W-1:0]               host_rdata,
    input logic                            loc_rd,
    input logic [SEL_W-1:0]                loc_sel,
    input logic                            loc_irq,
    input logic                            irq_en,
    input logic [NUM_IRQ-1:0]              pending,
    input logic                            queue_map,
    input logic [NUM_ALT-1:0][DATA_W-1:0]  mbox_lo
);
    logic mapped;
    always_comb begin
        mapped = (host_addr == AW'(CSR_ADDR)) || (host_addr == AW'(QCTL_ADDR));
        for (int i = 0; i < NUM_MBOX; i++)
            if (host_addr == AW'(MBOX_BASE + i)) mapped = 1'b1;
        for (int i = 0; i < NUM_ALT; i++)
            if (host_addr == AW'(ALT_BASE + i)) mapped = 1'b1;
    end

    // R7: interrupt needs the enable and a pending flag
    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_irq |-> irq_en);
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_irq |-> (|pending));

    // R10: unmapped words read zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !mapped) |=> (host_rdata == '0));

    // R4: queue-port writes leave the movable mailboxes alone
    for (genvar i = 0; i < NUM_ALT; i++) begin : g_qport
        assert_qport_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && queue_map && host_addr == AW'(MBOX_BASE + i)) |=> $stable(mbox_lo[i]));
    end

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_flag
        logic hit_n;
        if (n < NUM_ALT) begin : g_mov
            assign hit_n = ((host_addr == AW'(MBOX_BASE + n)) && !queue_map)
                         || (host_addr == AW'(ALT_BASE + n));
        end else begin : g_fix
            assign hit_n = (host_addr == AW'(MBOX_BASE + n));
        end

        // R5: a flag only rises after an enabled host write
        assert_flag_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[n]) |-> ($past(host_wr) && $past(irq_en)));

        // R8: a local read acknowledges unless a new message arrives together
        assert_local_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (loc_rd && loc_sel == SEL_W'(n) && !(host_wr && irq_en && hit_n)) |=> !pending[n]);
    end
endmodule

bind mbx_regfile mbx_regfile_chk #(
    .NUM_MBOX (NUM_MBOX),
    .NUM_IRQ  (NUM_IRQ),
    .NUM_ALT  (NUM_ALT),
    .DATA_W   (DATA_W),
    .AW       (AW),
    .MBOX_BASE(MBOX_BASE),
    .ALT_BASE (ALT_BASE),
    .CSR_ADDR (CSR_ADDR),
    .QCTL_ADDR(QCTL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_rdata(host_rdata),
    .loc_rd    (loc_rd),
    .loc_sel   (loc_sel),
    .loc_irq   (loc_irq),
    .irq_en    (irq_en_q),
    .pending   (pending),
    .queue_map (queue_map),
    .mbox_lo   (mbox_q[NUM_ALT-1:0])
);

// File: tb/mbx_regfile_tb.sv
module mbx_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd, loc_rd;
    logic [5:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata, loc_rdata;
    logic [2:0]  loc_sel;
    logic        loc_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [31:0] m_mb [8];
    logic [3:0]  m_st;
    logic        m_en;
    logic        m_q;
    logic [30:0] m_qup;

    always #5 clk = ~clk;

    mbx_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .loc_rd(loc_rd), .loc_sel(loc_sel), .loc_rdata(loc_rdata),
        .loc_irq(loc_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // mailbox index reached by a host word, -1 if none
    function automatic int mb_index(input logic [5:0] a);
        if (a >= 6'h12 && a <= 6'h17) return int'(a) - 'h10;
        if ((a == 6'h10 || a == 6'h11) && !m_q) return int'(a) - 'h10;
        if (a == 6'h1E || a == 6'h1F) return int'(a) - 'h1E;
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a);
        int k = mb_index(a);
        if (k >= 0) return m_mb[k];
        if (a == 6'h18) return {m_st, 24'h0, 4'h0} | (m_en ? 32'h8 : 32'h0);
        if (a == 6'h19) return {m_qup, m_q};
        return 32'h0;
    endfunction

    task automatic step(input logic hw, input logic [5:0] ha, input logic [31:0] hd,
                        input logic hr, input logic lr, input logic [2:0] li,
                        input string tag);
        logic [31:0] exp_h, exp_l;
        logic [3:0]  clr, set;
        int          k;
        host_wr = hw; host_addr = ha; host_wdata = hd; host_rd = hr;
        loc_rd = lr; loc_sel = li;
        exp_h = model_read(ha);
        exp_l = m_mb[li];
        k = mb_index(ha);
        clr = '0; set = '0;
        if (lr && li < 3'd4) clr[li[1:0]] = 1'b1;
        if (hw && ha == 6'h18) clr = clr | hd[31:28];
        if (hw && k >= 0 && k < 4 && m_en) set[k] = 1'b1;
        if (hw) begin
            if (k >= 0) m_mb[k] = hd;
            if (ha == 6'h18) m_en = hd[3];
            if (ha == 6'h19) begin m_q = hd[0]; m_qup = hd[31:1]; end
        end
        m_st = (m_st & ~clr) | set;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; loc_rd = 1'b0;
        if (hr) check({tag, " host read"}, host_rdata, exp_h);
        if (lr) check({tag, " local read"}, loc_rdata, exp_l);
        check({tag, " irq"}, {31'h0, loc_irq}, {31'h0, m_en && (|m_st)});
    endtask

    task automatic hwrite(input logic [5:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 1'b0, 3'd0, tag);
    endtask
    task automatic hread(input logic [5:0] a, input string tag);
        step(1'b0, a, 32'h0, 1'b1, 1'b0, 3'd0, tag);
    endtask
    task automatic lread(input logic [2:0] i, input string tag);
        step(1'b0, 6'h00, 32'h0, 1'b0, 1'b1, i, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; host_wr = 0; host_rd = 0; loc_rd = 0;
        host_addr = '0; host_wdata = '0; loc_sel = '0;
        for (int i = 0; i < 8; i++) m_mb[i] = '0;
        m_st = '0; m_en = 1'b0; m_q = 1'b0; m_qup = 31'h28;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 'h10; a <= 'h1F; a++) hread(6'(a), "R1");
        check("R1 qctl value", model_read(6'h19), 32'h50);

        // R2: store and read back from both sides
        hwrite(6'h15, 32'hDEAD_0005, "R2");
        hread(6'h15, "R2");
        lread(3'd5, "R2");

        // R5: no flag while disabled, flag once enabled
        hwrite(6'h12, 32'h1111_2222, "R5");
        hread(6'h18, "R5");
        hwrite(6'h18, 32'h0000_0008, "R9");
        hwrite(6'h12, 32'h3333_4444, "R5");
        hread(6'h18, "R5");

        // R6: high mailboxes raise nothing
        hwrite(6'h16, 32'h6666_6666, "R6");
        hread(6'h18, "R6");

        // R8: local read acknowledges, set wins when simultaneous
        lread(3'd2, "R8");
        hread(6'h18, "R8");
        hwrite(6'h11, 32'hAAAA_0001, "R8");
        step(1'b1, 6'h11, 32'hBBBB_0001, 1'b0, 1'b1, 3'd1, "R8 set wins");
        hread(6'h18, "R8");

        // R9: write-one-to-clear only the selected bits
        hwrite(6'h13, 32'h0303_0303, "R9");
        hwrite(6'h18, 32'h2000_0008, "R9");
        hread(6'h18, "R9");
        hwrite(6'h18, 32'h0000_0008, "R9");
        hread(6'h18, "R9");

        // R7: disabling masks irq but keeps status
        hwrite(6'h18, 32'h0000_0000, "R7");
        hread(6'h18, "R7");
        hwrite(6'h18, 32'h0000_0008, "R7");

        // R11 / R4: queue map
        hwrite(6'h19, 32'hC0DE_0051, "R11");
        hread(6'h19, "R11");
        hwrite(6'h10, 32'hBAD0_BAD0, "R4");
        hread(6'h10, "R4");
        hread(6'h11, "R4");
        hread(6'h18, "R4");
        hwrite(6'h1E, 32'h1E1E_0000, "R3");
        hread(6'h1E, "R3");
        lread(3'd0, "R3");

        // R3: alternate words in direct map
        hwrite(6'h19, 32'h0000_0050, "R11");
        hread(6'h10, "R3");
        hwrite(6'h1F, 32'h1F1F_1F1F, "R3");
        hread(6'h11, "R3");

        // R10: unmapped words
        hwrite(6'h05, 32'hFFFF_FFFF, "R10");
        hread(6'h05, "R10");
        hread(6'h3F, "R10");
        hread(6'h1A, "R10");

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int          r = $urandom_range(0, 99);
            logic [5:0]  a;
            logic [31:0] d = $urandom;
            if (r < 80)      a = 6'(6'h10 + $urandom_range(0, 15));
            else if (r < 88) a = 6'h18;
            else if (r < 92) a = 6'h19;
            else             a = 6'($urandom_range(0, 63));
            if (a == 6'h18) d[3] = ($urandom_range(0, 3) != 0);
            step($urandom_range(0, 1) == 1, a, d, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 2) == 0, 3'($urandom_range(0, 7)), "R2 R5 R7 R8");
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule